// File: doc/BRIEF.md
# UART Channel Mode Router with Byte FIFOs

This block sits between a UART's serializers and its register data port. It holds a receive byte FIFO and a transmit byte FIFO and steers every byte into them according to a 2-bit channel mode. In normal operation, line bytes are queued for software and register writes are queued for the line. In automatic echo, line bytes also go back out. In local loopback, register writes come back to the register side. In remote loopback, the line is reflected without software seeing it.

A 6-bit control word gates each direction. Each direction has an enable bit and a disable bit, and the word also carries a flush request for each FIFO. The line side sees a ready signal derived from the free space of whichever FIFOs the current mode writes. Overruns are reported as one-cycle pulses, and both FIFO occupancies are exported for a status block. Bit timing and serialization live elsewhere.

Top module: `uart_mode_router`

## Requirements
- R1: After synchronous reset, `ctl_q` is 0x28, `mode_q` is 0, both counts are 0, `line_out_valid` is 0 and `line_in_ready` is 1.
- R2: Control bit 2 enables RX and bit 3 disables it. Bit 4 enables TX and bit 5 disables it. A direction is active only with its enable bit at 1 and its disable bit at 0. An inactive direction drops every byte aimed at its FIFO, without an overrun. A data-port read while RX is inactive returns 0 and leaves the RX FIFO untouched.
- R3: A control write with bit 0 empties the RX FIFO, and one with bit 1 empties the TX FIFO, by the next cycle. Bits 1:0 of `ctl_q` always read back 0.
- R4: In mode 0 (normal), line bytes enter the RX FIFO and data-port writes enter the TX FIFO. Both FIFOs deliver bytes in arrival order. The TX FIFO is drained to `line_out_data` while `line_out_ready` is high.
- R5: In mode 1 (echo), each line byte enters both FIFOs, and data-port writes are dropped.
- R6: In mode 2 (local loopback), data-port writes enter the RX FIFO, ordinary line bytes are dropped, and nothing reaches the TX FIFO.
- R7: In mode 3 (remote loopback), line bytes enter only the TX FIFO, and data-port writes are dropped.
- R8: `line_in_ready` is low when the RX FIFO is full in modes 0 and 1, or when the TX FIFO is full in modes 1 and 3. It is high otherwise.
- R9: A byte bound for an active, full RX FIFO is dropped. `rx_overrun` is then high for exactly the following cycle, and the stored bytes are unchanged.
- R10: A byte bound for an active, full TX FIFO is dropped. `tx_overrun` is then high for exactly the following cycle.
- R11: `dp_rdata` updates the cycle after `dp_rd`. It returns 0 when the RX FIFO is empty.
- R12: A line event with `line_in_break` high stores 0x00 into the RX FIFO in every mode while RX is active, and never enters the TX FIFO.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_wr | input | 1 | Control word write strobe |
| ctl_wdata | input | 6 | Control word: 0 RX flush, 1 TX flush, 2 RX enable, 3 RX disable, 4 TX enable, 5 TX disable |
| mode_wr | input | 1 | Channel mode write strobe |
| mode_wdata | input | 2 | Channel mode: 0 normal, 1 echo, 2 local loop, 3 remote loop |
| ctl_q | output | 6 | Stored control word |
| mode_q | output | 2 | Stored channel mode |
| line_in_valid | input | 1 | Byte or break event from the receive serializer |
| line_in_break | input | 1 | Qualifies the event as a line break |
| line_in_data | input | 8 | Received byte |
| line_in_ready | output | 1 | Space available in the FIFOs the mode targets |
| line_out_valid | output | 1 | TX FIFO holds a byte |
| line_out_data | output | 8 | Head byte of the TX FIFO |
| line_out_ready | input | 1 | Transmit serializer takes the head byte |
| dp_wr | input | 1 | Register data port write |
| dp_wdata | input | 8 | Register data port write byte |
| dp_rd | input | 1 | Register data port read |
| dp_rdata | output | 8 | Register data port read byte, valid the cycle after `dp_rd` |
| rx_count | output | 7 | RX FIFO occupancy |
| tx_count | output | 7 | TX FIFO occupancy |
| rx_overrun | output | 1 | RX overrun pulse |
| tx_overrun | output | 1 | TX overrun pulse |

## Verification
The hardest states to reach are the full-FIFO edges: ready going low, and overrun on the 65th byte. They take a full 64 entries, and in loopback and echo modes the same full FIFO must be checked against a different mode. The bench fills the RX FIFO once through line events in normal mode. It then switches the mode under the full FIFO to watch `line_in_ready` follow the mode, before driving one more byte to provoke the overrun. Inactive-direction reads are reached by toggling the disable bit while data sits in the FIFO.

// File: rtl/uart_route_pkg.sv
package uart_route_pkg;
  typedef enum logic [1:0] {
    CH_NORMAL = 2'd0,
    CH_ECHO   = 2'd1,
    CH_LOCAL  = 2'd2,
    CH_REMOTE = 2'd3
  } ch_mode_e;

  localparam int CTL_W     = 6;
  localparam int CB_RXFLSH = 0;
  localparam int CB_TXFLSH = 1;
  localparam int CB_RXEN   = 2;
  localparam int CB_RXDIS  = 3;
  localparam int CB_TXEN   = 4;
  localparam int CB_TXDIS  = 5;
  localparam logic [CTL_W-1:0] CTL_RESET = 6'h28;
endpackage

// File: rtl/uart_byte_fifo.sv
module uart_byte_fifo #(
  parameter int DEPTH = 64,
  parameter int DW    = 8
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       flush,
  input  logic                       push,
  input  logic [DW-1:0]              din,
  input  logic                       pop,
  output logic [DW-1:0]              dout,
  output logic [$clog2(DEPTH+1)-1:0] count,
  output logic                       full,
  output logic                       empty
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH+1);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic          do_push, do_pop;

  assign full    = (count == CW'(DEPTH));
  assign empty   = (count == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign dout    = mem[rd_ptr];

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH-1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) wr_ptr <= bump(wr_ptr);
      if (do_pop)  rd_ptr <= bump(rd_ptr);
      case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  p_count_bound_r9: assert property (@(posedge clk) disable iff (rst)
    count <= CW'(DEPTH));
  p_full_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (push && full && !pop && !flush) |=> (count == CW'(DEPTH)));
  p_flush_empty_r3: assert property (@(posedge clk) disable iff (rst)
    flush |=> (count == '0));
endmodule

// File: rtl/uart_ctl_regs.sv
module uart_ctl_regs
  import uart_route_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             ctl_wr,
  input  logic [CTL_W-1:0] ctl_wdata,
  input  logic             mode_wr,
  input  logic [1:0]       mode_wdata,
  output logic [CTL_W-1:0] ctl_q,
  output ch_mode_e         mode_q,
  output logic             rx_flush,
  output logic             tx_flush,
  output logic             rx_on,
  output logic             tx_on
);
  localparam logic [CTL_W-1:0] FLUSH_MASK =
    (CTL_W'(1) << CB_RXFLSH) | (CTL_W'(1) << CB_TXFLSH);

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_q  <= CTL_RESET;
      mode_q <= CH_NORMAL;
    end else begin
      if (ctl_wr)  ctl_q  <= ctl_wdata & ~FLUSH_MASK;
      if (mode_wr) mode_q <= ch_mode_e'(mode_wdata);
    end
  end

  assign rx_flush = ctl_wr && ctl_wdata[CB_RXFLSH];
  assign tx_flush = ctl_wr && ctl_wdata[CB_TXFLSH];
  assign rx_on    = ctl_q[CB_RXEN] && !ctl_q[CB_RXDIS];
  assign tx_on    = ctl_q[CB_TXEN] && !ctl_q[CB_TXDIS];
endmodule

// File: rtl/uart_route_logic.sv
module uart_route_logic
  import uart_route_pkg::*;
(
  input  ch_mode_e   mode,
  input  logic       rx_on,
  input  logic       tx_on,
  input  logic       line_valid,
  input  logic       line_break,
  input  logic [7:0] line_data,
  input  logic       dp_wr,
  input  logic [7:0] dp_wdata,
  input  logic       rx_full,
  input  logic       tx_full,
  output logic       rx_push,
  output logic [7:0] rx_din,
  output logic       tx_push,
  output logic [7:0] tx_din,
  output logic       rx_ovr_evt,
  output logic       tx_ovr_evt,
  output logic       line_ready
);
  logic line_to_rx, line_to_tx, rx_req, tx_req;

  assign line_to_rx = (mode == CH_NORMAL) || (mode == CH_ECHO);
  assign line_to_tx = (mode == CH_ECHO)   || (mode == CH_REMOTE);

  always_comb begin
    rx_req = 1'b0;
    tx_req = 1'b0;
    rx_din = line_data;
    tx_din = line_data;
    if (line_valid && line_break) begin
      rx_req = 1'b1;
      rx_din = 8'h00;
    end else if (line_valid) begin
      rx_req = line_to_rx;
      tx_req = line_to_tx;
    end
    if (dp_wr && mode == CH_NORMAL) begin
      tx_req = 1'b1;
      tx_din = dp_wdata;
    end else if (dp_wr && mode == CH_LOCAL && !rx_req) begin
      rx_req = 1'b1;
      rx_din = dp_wdata;
    end
  end

  assign rx_push    = rx_req && rx_on && !rx_full;
  assign rx_ovr_evt = rx_req && rx_on && rx_full;
  assign tx_push    = tx_req && tx_on && !tx_full;
  assign tx_ovr_evt = tx_req && tx_on && tx_full;
  assign line_ready = !(line_to_rx && rx_full) && !(line_to_tx && tx_full);
endmodule

// File: rtl/uart_mode_router.sv
module uart_mode_router
  import uart_route_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int CW    = $clog2(DEPTH+1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ctl_wr,
  input  logic [CTL_W-1:0] ctl_wdata,
  input  logic             mode_wr,
  input  logic [1:0]       mode_wdata,
  output logic [CTL_W-1:0] ctl_q,
  output logic [1:0]       mode_q,
  input  logic             line_in_valid,
  input  logic             line_in_break,
  input  logic [7:0]       line_in_data,
  output logic             line_in_ready,
  output logic             line_out_valid,
  output logic [7:0]       line_out_data,
  input  logic             line_out_ready,
  input  logic             dp_wr,
  input  logic [7:0]       dp_wdata,
  input  logic             dp_rd,
  output logic [7:0]       dp_rdata,
  output logic [CW-1:0]    rx_count,
  output logic [CW-1:0]    tx_count,
  output logic             rx_overrun,
  output logic             tx_overrun
);
  ch_mode_e   mode;
  logic       rx_flush, tx_flush, rx_on, tx_on;
  logic       rx_push, tx_push, rx_pop, tx_pop;
  logic [7:0] rx_din, tx_din, rx_dout;
  logic       rx_full, tx_full, rx_empty, tx_empty;
  logic       rx_ovr_evt, tx_ovr_evt;

  uart_ctl_regs u_ctl (
    .clk(clk), .rst(rst), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
    .mode_wr(mode_wr), .mode_wdata(mode_wdata), .ctl_q(ctl_q),
    .mode_q(mode), .rx_flush(rx_flush), .tx_flush(tx_flush),
    .rx_on(rx_on), .tx_on(tx_on)
  );
  assign mode_q = mode;

  uart_route_logic u_route (
    .mode(mode), .rx_on(rx_on), .tx_on(tx_on),
    .line_valid(line_in_valid), .line_break(line_in_break),
    .line_data(line_in_data), .dp_wr(dp_wr), .dp_wdata(dp_wdata),
    .rx_full(rx_full), .tx_full(tx_full), .rx_push(rx_push),
    .rx_din(rx_din), .tx_push(tx_push), .tx_din(tx_din),
    .rx_ovr_evt(rx_ovr_evt), .tx_ovr_evt(tx_ovr_evt),
    .line_ready(line_in_ready)
  );

  assign rx_pop = dp_rd && rx_on && !rx_empty;
  assign tx_pop = line_out_ready && !tx_empty;

  uart_byte_fifo #(.DEPTH(DEPTH), .DW(8)) u_rx_fifo (
    .clk(clk), .rst(rst), .flush(rx_flush), .push(rx_push), .din(rx_din),
    .pop(rx_pop), .dout(rx_dout), .count(rx_count), .full(rx_full),
    .empty(rx_empty)
  );

  uart_byte_fifo #(.DEPTH(DEPTH), .DW(8)) u_tx_fifo (
    .clk(clk), .rst(rst), .flush(tx_flush), .push(tx_push), .din(tx_din),
    .pop(tx_pop), .dout(line_out_data), .count(tx_count), .full(tx_full),
    .empty(tx_empty)
  );

  assign line_out_valid = !tx_empty;

  always_ff @(posedge clk) begin
    if (rst) begin
      dp_rdata   <= 8'h00;
      rx_overrun <= 1'b0;
      tx_overrun <= 1'b0;
    end else begin
      if (dp_rd) dp_rdata <= rx_pop ? rx_dout : 8'h00;
      rx_overrun <= rx_ovr_evt;
      tx_overrun <= tx_ovr_evt;
    end
  end

  p_rx_ovr_full_r9: assert property (@(posedge clk) disable iff (rst)
    rx_overrun |-> ($past(rx_count) == CW'(DEPTH)));
  p_tx_ovr_full_r10: assert property (@(posedge clk) disable iff (rst)
    tx_overrun |-> ($past(tx_count) == CW'(DEPTH)));
  p_empty_read_zero_r11: assert property (@(posedge clk) disable iff (rst)
    (dp_rd && rx_count == '0) |=> (dp_rdata == 8'h00));
  p_off_read_keeps_r2: assert property (@(posedge clk) disable iff (rst)
    (dp_rd && !rx_on && !rx_flush && !rx_push) |=> (rx_count == $past(rx_count)));
  p_local_no_tx_r6: assert property (@(posedge clk) disable iff (rst)
    (mode == CH_LOCAL && tx_count == '0) |=> (tx_count == '0));
  p_ready_low_full_r8: assert property (@(posedge clk) disable iff (rst)
    (mode == CH_NORMAL && rx_count == CW'(DEPTH)) |-> !line_in_ready);
endmodule

// File: tb/uart_mode_router_bench.sv
module uart_mode_router_bench;
  localparam int DEPTH = 64;
  localparam int CW    = $clog2(DEPTH+1);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ctl_wr = 1'b0;
  logic [5:0] ctl_wdata = '0;
  logic mode_wr = 1'b0;
  logic [1:0] mode_wdata = '0;
  logic [5:0] ctl_q;
  logic [1:0] mode_q;
  logic line_in_valid = 1'b0, line_in_break = 1'b0;
  logic [7:0] line_in_data = '0;
  logic line_in_ready, line_out_valid, line_out_ready = 1'b0;
  logic [7:0] line_out_data;
  logic dp_wr = 1'b0, dp_rd = 1'b0;
  logic [7:0] dp_wdata = '0, dp_rdata;
  logic [CW-1:0] rx_count, tx_count;
  logic rx_overrun, tx_overrun;

  int n_chk = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  uart_mode_router #(.DEPTH(DEPTH)) u_uart_mode_router (
    .clk(clk), .rst(rst), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
    .mode_wr(mode_wr), .mode_wdata(mode_wdata), .ctl_q(ctl_q),
    .mode_q(mode_q), .line_in_valid(line_in_valid),
    .line_in_break(line_in_break), .line_in_data(line_in_data),
    .line_in_ready(line_in_ready), .line_out_valid(line_out_valid),
    .line_out_data(line_out_data), .line_out_ready(line_out_ready),
    .dp_wr(dp_wr), .dp_wdata(dp_wdata), .dp_rd(dp_rd),
    .dp_rdata(dp_rdata), .rx_count(rx_count), .tx_count(tx_count),
    .rx_overrun(rx_overrun), .tx_overrun(tx_overrun)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic set_ctl(input logic [5:0] v);
    ctl_wr = 1'b1; ctl_wdata = v; step(); ctl_wr = 1'b0;
  endtask

  task automatic set_mode(input logic [1:0] m);
    mode_wr = 1'b1; mode_wdata = m; step(); mode_wr = 1'b0;
  endtask

  task automatic line_send(input logic [7:0] b, input logic brk);
    line_in_valid = 1'b1; line_in_data = b; line_in_break = brk;
    step();
    line_in_valid = 1'b0; line_in_break = 1'b0;
  endtask

  task automatic dp_write(input logic [7:0] b);
    dp_wr = 1'b1; dp_wdata = b; step(); dp_wr = 1'b0;
  endtask

  task automatic dp_read(output logic [7:0] b);
    dp_rd = 1'b1; step(); dp_rd = 1'b0; b = dp_rdata;
  endtask

  task automatic tx_pull(output logic [7:0] b);
    b = line_out_data;
    line_out_ready = 1'b1; step(); line_out_ready = 1'b0;
  endtask

  task automatic flush_all();
    set_ctl(6'h17);
  endtask

  task automatic t_reset();
    chk("R1 ctl_q", ctl_q, 6'h28);
    chk("R1 mode_q", mode_q, 0);
    chk("R1 rx_count", rx_count, 0);
    chk("R1 tx_count", tx_count, 0);
    chk("R1 line_out_valid", line_out_valid, 0);
    chk("R1 line_in_ready", line_in_ready, 1);
  endtask

  task automatic t_enables();
    logic [7:0] b;
    line_send(8'h11, 1'b0);
    chk("R2 rx dropped when disabled", rx_count, 0);
    dp_write(8'h22);
    chk("R2 tx dropped when disabled", tx_count, 0);
    set_ctl(6'h0C);
    line_send(8'h11, 1'b0);
    chk("R2 enable+disable still off", rx_count, 0);
    set_ctl(6'h14);
    line_send(8'h11, 1'b0);
    chk("R2 rx active", rx_count, 1);
    set_ctl(6'h18);
    dp_read(b);
    chk("R2 read while off returns 0", b, 0);
    chk("R2 read while off keeps count", rx_count, 1);
    set_ctl(6'h14);
    dp_read(b);
    chk("R2 read after re-enable", b, 8'h11);
  endtask

  task automatic t_normal();
    logic [7:0] b;
    set_mode(2'd0);
    line_send(8'hA1, 1'b0); line_send(8'hA2, 1'b0); line_send(8'hA3, 1'b0);
    dp_write(8'hB1); dp_write(8'hB2);
    chk("R4 rx count", rx_count, 3);
    chk("R4 tx count", tx_count, 2);
    chk("R4 line_out_valid", line_out_valid, 1);
    dp_read(b); chk("R4 rx order 0", b, 8'hA1);
    dp_read(b); chk("R4 rx order 1", b, 8'hA2);
    dp_read(b); chk("R4 rx order 2", b, 8'hA3);
    tx_pull(b); chk("R4 tx order 0", b, 8'hB1);
    tx_pull(b); chk("R4 tx order 1", b, 8'hB2);
    chk("R4 tx drained", line_out_valid, 0);
  endtask

  task automatic t_echo();
    logic [7:0] b;
    set_mode(2'd1);
    line_send(8'hC1, 1'b0); line_send(8'hC2, 1'b0);
    chk("R5 rx count", rx_count, 2);
    chk("R5 tx count", tx_count, 2);
    dp_write(8'h99);
    chk("R5 dp write dropped", tx_count, 2);
    tx_pull(b); chk("R5 echoed byte", b, 8'hC1);
    flush_all();
    chk("R3 ctl flush bits read 0", ctl_q, 6'h14);
    chk("R3 rx flushed", rx_count, 0);
    chk("R3 tx flushed", tx_count, 0);
  endtask

  task automatic t_local();
    logic [7:0] b;
    set_mode(2'd2);
    dp_write(8'h5A);
    chk("R6 dp write into rx", rx_count, 1);
    line_send(8'h33, 1'b0);
    chk("R6 line byte dropped", rx_count, 1);
    chk("R6 no tx", line_out_valid, 0);
    dp_read(b); chk("R6 looped byte", b, 8'h5A);
  endtask

  task automatic t_remote();
    logic [7:0] b;
    set_mode(2'd3);
    line_send(8'h77, 1'b0);
    chk("R7 tx count", tx_count, 1);
    chk("R7 rx untouched", rx_count, 0);
    dp_write(8'h66);
    chk("R7 dp write dropped", tx_count, 1);
    tx_pull(b); chk("R7 reflected byte", b, 8'h77);
  endtask

  task automatic t_flush();
    set_mode(2'd0);
    line_send(8'h01, 1'b0); line_send(8'h02, 1'b0);
    dp_write(8'h03); dp_write(8'h04);
    set_ctl(6'h15);
    chk("R3 rx flush", rx_count, 0);
    chk("R3 tx kept", tx_count, 2);
    chk("R3 ctl bit0 clear", ctl_q, 6'h14);
    set_ctl(6'h16);
    chk("R3 tx flush", tx_count, 0);
  endtask

  task automatic t_full_rx();
    logic [7:0] b;
    set_mode(2'd0);
    for (int i = 0; i < DEPTH; i++) line_send(8'(i + 1), 1'b0);
    chk("R8 rx full count", rx_count, DEPTH);
    chk("R8 normal ready low", line_in_ready, 0);
    set_mode(2'd1);
    chk("R8 echo ready low", line_in_ready, 0);
    set_mode(2'd3);
    chk("R8 remote ready high", line_in_ready, 1);
    set_mode(2'd2);
    chk("R8 local ready high", line_in_ready, 1);
    set_mode(2'd0);
    line_send(8'hEE, 1'b0);
    chk("R9 overrun pulse", rx_overrun, 1);
    chk("R9 count held", rx_count, DEPTH);
    step();
    chk("R9 overrun one cycle", rx_overrun, 0);
    dp_read(b); chk("R9 head intact", b, 8'h01);
    flush_all();
  endtask

  task automatic t_full_tx();
    logic [7:0] b;
    set_mode(2'd0);
    for (int i = 0; i < DEPTH; i++) dp_write(8'(i + 8'h40));
    chk("R10 tx full count", tx_count, DEPTH);
    dp_write(8'hFE);
    chk("R10 overrun pulse", tx_overrun, 1);
    chk("R10 count held", tx_count, DEPTH);
    step();
    chk("R10 overrun one cycle", tx_overrun, 0);
    tx_pull(b); chk("R10 head intact", b, 8'h40);
    flush_all();
  endtask

  task automatic t_empty_read();
    logic [7:0] b;
    line_send(8'h5C, 1'b0);
    dp_read(b); chk("R11 read data", b, 8'h5C);
    dp_read(b); chk("R11 empty read zero", b, 0);
  endtask

  task automatic t_break();
    logic [7:0] b;
    set_mode(2'd1);
    line_send(8'hFF, 1'b1);
    chk("R12 break in rx", rx_count, 1);
    chk("R12 break not echoed", tx_count, 0);
    dp_read(b); chk("R12 break byte", b, 0);
    set_mode(2'd3);
    line_send(8'hFF, 1'b1);
    chk("R12 break in rx remote", rx_count, 1);
    chk("R12 break not in tx remote", tx_count, 0);
    flush_all();
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    step();
    t_reset();
    t_enables();
    t_normal();
    t_echo();
    t_local();
    t_remote();
    t_flush();
    t_full_rx();
    t_full_tx();
    t_empty_read();
    t_break();
    summary();
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: run did not finish");
    summary();
    $finish;
  end
endmodule